// File: doc/BRIEF.md
# Alternating Two-Phase Pulse Shaper

This block sits behind a rate synthesizer and turns its single-cycle rate events into pulses long enough to drive slow loads. Each event on the phase input produces one active-low pulse. Successive pulses go to two pins in turn, so a two-phase stepper or an electromechanical counter advances once per event. A second event input produces an active-high calibration pulse stream. That stream runs at a higher rate and has a shorter nominal width.

Each path measures its own event period as the number of clock edges between consecutive events. When events are sparse, a pulse has a fixed nominal width. When the period is shorter than twice that width, the pulse shrinks to half the period, so it always ends before the next event. If an event arrives while a phase pulse is still active, it waits in a one-deep slot. It is then issued on the edge where the active pulse ends, which keeps the two phase pins from being low together.

All widths are counts of the master clock and are set by parameters.

Top module: `twophase_shaper`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `ph0_n` and `ph1_n` high and `cal_p` low. The next phase pulse goes to `ph0_n`. Both period measurements restart as "long", so the first pulse after reset has the full nominal width.
- R2: A phase event sampled at a clock edge drives the selected phase pin low from that edge for exactly `PH_W` clock cycles when the measured period is at least 2*`PH_W` cycles.
- R3: When the measured phase period P (clock edges between the previous event and this one) is below 2*`PH_W`, the pulse lasts floor(P/2) cycles, with a minimum of 1 cycle.
- R4: Phase pulses alternate between pins: the first goes to `ph0_n`, the second to `ph1_n`, and so on.
- R5: `ph0_n` and `ph1_n` are never low in the same cycle.
- R6: A phase event arriving while a phase pulse is active (except in its last cycle) is held and starts on the edge where the active pulse ends. Its width comes from the period measured at its own arrival. Only one event is held, and further events that arrive while one is held are dropped.
- R7: A calibration event drives `cal_p` high for `CAL_W` cycles, or for floor(P/2) cycles (minimum 1) when its own measured period P is below 2*`CAL_W`. Calibration events do not affect the phase pins, and phase events do not affect `cal_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_evt | input | 1 | Single-cycle phase rate event |
| cal_evt | input | 1 | Single-cycle calibration rate event |
| ph0_n | output | 1 | First phase output, active low |
| ph1_n | output | 1 | Second phase output, active low |
| cal_p | output | 1 | Calibration pulse output, active high |

## Verification
An event held high across a rising edge changes the outputs at that same edge. The first cycle of the pulse is therefore the one that follows that edge, and the pulse then lasts exactly its width in cycles. A held event starts at the edge where the previous pulse's last cycle ends. The bench drives inputs and samples outputs only on falling edges. Each observation window is longer than the pulses it contains, so every window covers a pulse from its first cycle to its last. The bench checks the index of the first low or high sample and the total count of such samples against widths worked out from the gaps it drove.

// File: rtl/twophase_shaper.sv
module twophase_shaper #(
  parameter int PH_W  = 68750000,
  parameter int CAL_W = 22500000,
  parameter int CNT_W = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_evt,
  input  logic cal_evt,
  output logic ph0_n,
  output logic ph1_n,
  output logic cal_p
);
  localparam logic [CNT_W-1:0] PH_FULL  = CNT_W'(PH_W);
  localparam logic [CNT_W-1:0] CAL_FULL = CNT_W'(CAL_W);

  function automatic logic [CNT_W-1:0] pick(input logic [CNT_W-1:0] per,
                                            input logic [CNT_W-1:0] full);
    if ({1'b0, per} < {full, 1'b0})
      pick = (per < CNT_W'(2)) ? CNT_W'(1) : (per >> 1);
    else
      pick = full;
  endfunction

  // period counters: saturate at all ones, which reads as "long"
  logic [CNT_W-1:0] ph_per, cal_per;
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_per  <= '1;
      cal_per <= '1;
    end else begin
      if (rate_evt) ph_per <= CNT_W'(1);
      else if (ph_per != '1) ph_per <= ph_per + 1'b1;
      if (cal_evt) cal_per <= CNT_W'(1);
      else if (cal_per != '1) cal_per <= cal_per + 1'b1;
    end
  end

  // phase path
  logic [CNT_W-1:0] ph_rem, ph_pw, ph_new;
  logic ph_pend, ph_cur, ph_nxt, ph_free;
  assign ph_new  = pick(ph_per, PH_FULL);
  assign ph_free = ph_rem <= CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_rem  <= '0;
      ph_pw   <= '0;
      ph_pend <= 1'b0;
      ph_cur  <= 1'b0;
      ph_nxt  <= 1'b0;
    end else if (ph_free && (ph_pend || rate_evt)) begin
      ph_rem  <= ph_pend ? ph_pw : ph_new;
      ph_cur  <= ph_nxt;
      ph_nxt  <= ~ph_nxt;
      ph_pend <= ph_pend && rate_evt;
      if (ph_pend && rate_evt) ph_pw <= ph_new;
    end else begin
      if (ph_rem != '0) ph_rem <= ph_rem - 1'b1;
      if (rate_evt && !ph_pend) begin
        ph_pend <= 1'b1;
        ph_pw   <= ph_new;
      end
    end
  end

  assign ph0_n = !((ph_rem != '0) && !ph_cur);
  assign ph1_n = !((ph_rem != '0) && ph_cur);

  // calibration path
  logic [CNT_W-1:0] cal_rem, cal_pw, cal_new;
  logic cal_pend, cal_free;
  assign cal_new  = pick(cal_per, CAL_FULL);
  assign cal_free = cal_rem <= CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_rem  <= '0;
      cal_pw   <= '0;
      cal_pend <= 1'b0;
    end else if (cal_free && (cal_pend || cal_evt)) begin
      cal_rem  <= cal_pend ? cal_pw : cal_new;
      cal_pend <= cal_pend && cal_evt;
      if (cal_pend && cal_evt) cal_pw <= cal_new;
    end else begin
      if (cal_rem != '0) cal_rem <= cal_rem - 1'b1;
      if (cal_evt && !cal_pend) begin
        cal_pend <= 1'b1;
        cal_pw   <= cal_new;
      end
    end
  end

  assign cal_p = cal_rem != '0;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (ph0_n && ph1_n && !cal_p));
  a_r5_phases_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!ph0_n && !ph1_n));
  a_r2_phase_width_cap: assert property (@(posedge clk) disable iff (rst)
    ph_rem <= PH_FULL);
  a_r7_cal_width_cap: assert property (@(posedge clk) disable iff (rst)
    cal_rem <= CAL_FULL);
  a_r6_held_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    ph_pend |-> (!ph0_n || !ph1_n));
endmodule

// File: tb/sim_twophase_shaper.sv
module sim_twophase_shaper;
  localparam int PW = 20;
  localparam int CW = 6;
  localparam int NW = 12;
  localparam int NV = 11;
  localparam int GAPS [NV] = '{50, 30, 30, 41, 39, 39, 40, 24, 24, 20, 60};
  localparam int WIDS [NV] = '{20, 20, 15, 15, 20, 19, 19, 20, 12, 12, 10};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_evt = 1'b0;
  logic cal_evt = 1'b0;
  logic ph0_n, ph1_n, cal_p;
  int total = 0, bad = 0;
  int a_cnt, b_cnt, c_cnt, a_first, b_first, c_first, both;

  twophase_shaper #(.PH_W(PW), .CAL_W(CW), .CNT_W(NW)) u0 (
    .clk(clk), .rst(rst), .rate_evt(rate_evt), .cal_evt(cal_evt),
    .ph0_n(ph0_n), .ph1_n(ph1_n), .cal_p(cal_p));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n, input int e0, input int e1, input int e2, input int c0);
    a_cnt = 0; b_cnt = 0; c_cnt = 0; both = 0;
    a_first = -1; b_first = -1; c_first = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!ph0_n) begin a_cnt++; if (a_first < 0) a_first = i; end
      if (!ph1_n) begin b_cnt++; if (b_first < 0) b_first = i; end
      if (cal_p) begin c_cnt++; if (c_first < 0) c_first = i; end
      if (!ph0_n && !ph1_n) both++;
      rate_evt = (i == e0) || (i == e1) || (i == e2);
      cal_evt = (i == c0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rate_evt = 1'b0; cal_evt = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #800000;
    chk("R2 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset ph0_n", int'(ph0_n), 1);
    chk("R1 reset ph1_n", int'(ph1_n), 1);
    chk("R1 reset cal_p", int'(cal_p), 0);

    for (int k = 0; k < NV; k++) begin
      run(GAPS[k], 0, -1, -1, -1);
      if (k % 2 == 0) begin
        chk("R4 even pulse on ph0 first", a_first, 1);
        chk((WIDS[k] == PW) ? "R2 full width ph0" : "R3 half period ph0", a_cnt, WIDS[k]);
        chk("R4 ph1 idle on even pulse", b_cnt, 0);
      end else begin
        chk("R4 odd pulse on ph1 first", b_first, 1);
        chk((WIDS[k] == PW) ? "R2 full width ph1" : "R3 half period ph1", b_cnt, WIDS[k]);
        chk("R4 ph0 idle on odd pulse", a_cnt, 0);
      end
      chk("R5 no overlap", both, 0);
      chk("R7 cal untouched by phase events", c_cnt, 0);
    end

    // R6 held event follows at once, width from its own period (5 -> 2)
    do_reset();
    run(50, 0, 5, -1, -1);
    chk("R6 first pulse width", a_cnt, PW);
    chk("R6 first pulse start", a_first, 1);
    chk("R6 held pulse start", b_first, 21);
    chk("R6 held pulse width", b_cnt, 2);
    chk("R5 no overlap on handover", both, 0);

    // R3 minimum width: period 1 gives 1 cycle
    do_reset();
    run(40, 0, 1, -1, -1);
    chk("R3 min width", b_cnt, 1);
    chk("R3 min width start", b_first, 21);

    // R6 third event dropped while one is held
    do_reset();
    run(60, 0, 3, 6, -1);
    chk("R6 first width with drops", a_cnt, PW);
    chk("R6 only one held pulse", b_cnt, 1);

    // R1 reset in the middle of a pulse
    do_reset();
    run(5, 0, -1, -1, -1);
    chk("R1 pulse active before reset", int'(ph0_n), 0);
    do_reset();
    chk("R1 mid-pulse reset ph0_n", int'(ph0_n), 1);
    chk("R1 mid-pulse reset ph1_n", int'(ph1_n), 1);
    run(30, 0, -1, -1, -1);
    chk("R1 next pulse on ph0", a_first, 1);
    chk("R1 full width after reset", a_cnt, PW);
    chk("R1 ph1 idle after reset", b_cnt, 0);

    // R7 calibration path
    do_reset();
    run(30, -1, -1, -1, 0);
    chk("R7 cal first width", c_cnt, CW);
    chk("R7 cal start", c_first, 1);
    chk("R7 phases untouched by cal", a_cnt + b_cnt, 0);
    run(20, -1, -1, -1, 0);
    chk("R7 cal full width", c_cnt, CW);
    run(8, -1, -1, -1, 0);
    chk("R7 cal width after long period", c_cnt, CW);
    run(20, -1, -1, -1, 0);
    chk("R7 cal half period", c_cnt, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule